// File: doc/BRIEF.md
# Sector Write-Protection Guard with Key-Unlocked Gate

This block decides, for every sector of a flash array, whether program and erase may touch it. It holds two bit vectors with one bit per sector: a dynamic vector that is lost on any reset, and a persistent vector that survives a hardware reset and is only cleared by power-on. A bit value of 1 means "unprotected" in both vectors. A sector is protected when either of its two bits is 0. A query port returns a 3-bit status word and a protected flag for any sector, combinationally.

Changes to the persistent vector are allowed only while a gate bit is 1. A one-time configuration input selects how the gate behaves. In latch mode, the gate opens at reset and can then only be closed. In key mode, the gate is closed at reset. It opens after a 64-bit key, written as four 16-bit words, matches a fixed parameter value, and a command can close it again. The gate is a four-state machine. `LK_OPEN` means the gate is 1. `LK_SHUT` means the gate is 0 and can be reopened with the key. `LK_SEALED` means the gate is 0 for good until the next reset. `LK_CHECK` is a one-cycle comparison of a completed key. The transitions are:
- reset → `LK_OPEN` (latch mode) or `LK_SHUT` (key mode);
- `LK_OPEN` –close→ `LK_SEALED` (latch mode) or `LK_SHUT` (key mode);
- `LK_SHUT` –last key word with all others present→ `LK_CHECK`;
- `LK_CHECK` –match→ `LK_OPEN`;
- `LK_CHECK` –mismatch or close→ `LK_SHUT`;
- `LK_SEALED` is left only by reset.

Top module: `sector_guard`

## Requirements
- R1: While `por_n` is 0 at a clock edge, every dynamic and every persistent bit becomes 1 (unprotected).
- R2: While `rst_n` is 0 and `por_n` is 1 at a clock edge, every dynamic bit becomes 1, every persistent bit keeps its value, and no command has any effect.
- R3: `status_out` for `query_sector` is combinational. Bit 1 is the sector's dynamic bit and bit 2 is its persistent bit. Bit 0 is 1 only when both are 1. `prot_out` is the inverse of bit 0.
- R4: With `cmd_valid` high, op 1 writes 0 and op 2 writes 1 to the dynamic bit of sector `cmd_addr`, whatever the gate state. The change is visible after that edge.
- R5: With `cmd_valid` high and `gate_out` 1, op 3 writes 0 to the persistent bit of sector `cmd_addr`, and op 4 sets all persistent bits to 1. With `gate_out` 0, both ops leave every persistent bit unchanged.
- R6: In latch mode (`pw_mode`=0), `gate_out` is 1 after reset. Op 5 makes it 0, and it stays 0 until the next reset; key words (op 6) have no effect.
- R7: In key mode (`pw_mode`=1), `gate_out` is 0 after reset, and op 5 makes it 0 from any state.
- R8: In key mode with the gate at 0, op 6 stores `cmd_data` as key word `cmd_addr[1:0]`. Word 0 holds key bits 15:0 and word 3 holds bits 63:48. Words 0 to 2 may arrive in any order. If word 3 arrives after words 0 to 2 were all stored, `gate_out` becomes 1 one clock edge later, provided the four words equal `KEY`. On a mismatch, or when word 3 arrives early, `gate_out` stays 0 and the stored words are discarded.
- R9: Op 0 and op 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| pw_mode | input | 1 | Gate mode: 0 latch, 1 key; held static |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_op | input | 3 | Operation code (0..7) |
| cmd_addr | input | SW | Sector index, or key word offset in bits 1:0 |
| cmd_data | input | 16 | Key word value |
| query_sector | input | SW | Sector whose protection is reported |
| status_out | output | 3 | {persistent, dynamic, both-unprotected} |
| prot_out | output | 1 | 1 when the queried sector is protected |
| gate_out | output | 1 | 1 when persistent bits may change |

## Verification
The assertions assume that `pw_mode` is fixed between power-on resets. They also assume that the resets are sampled on clock edges, so that the gate state, the collected key words and both vectors change only at edges. The bench changes `pw_mode` only while `por_n` is low. It drives every command for exactly one cycle and away from the clock edge. Its random phases draw ops and sectors from the full legal range, and key attempts are issued as directed sequences whose timing the gate model follows.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int KEY_WORDS  = 4;
    localparam int KEY_WORD_W = 16;
    localparam int KEY_IDX_W  = $clog2(KEY_WORDS);

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_DYN_LOCK   = 3'd1,
        OP_DYN_FREE   = 3'd2,
        OP_PER_PROG   = 3'd3,
        OP_PER_WIPE   = 3'd4,
        OP_GATE_CLOSE = 3'd5,
        OP_KEY_WORD   = 3'd6,
        OP_RSVD       = 3'd7
    } sg_op_e;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_SHUT   = 2'd1,
        LK_SEALED = 2'd2,
        LK_CHECK  = 2'd3
    } sg_lock_e;
endpackage

// File: rtl/sg_bit_array.sv
module sg_bit_array #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          set_val,
    input  logic          fill_en,
    input  logic          fill_val,
    input  logic [AW-1:0] rd_idx,
    output logic          rd_bit,
    output logic [N-1:0]  bits
);
    logic [N-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (clr)
            bits_q <= '1;
        else if (fill_en)
            bits_q <= {N{fill_val}};
        else if (set_en)
            bits_q[set_idx] <= set_val;
    end

    assign rd_bit = bits_q[rd_idx];
    assign bits   = bits_q;
endmodule

// File: rtl/sg_key_gate.sv
module sg_key_gate
    import sg_pkg::*;
#(
    parameter logic [63:0] KEY = 64'hC3A5_0F1E_7B29_D486
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic                  pw_mode,
    input  logic                  close_req,
    input  logic                  word_en,
    input  logic [KEY_IDX_W-1:0]  word_idx,
    input  logic [KEY_WORD_W-1:0] word_val,
    output logic                  gate
);
    localparam logic [KEY_IDX_W-1:0] LAST = KEY_IDX_W'(KEY_WORDS - 1);

    sg_lock_e state_q, state_d;
    logic [KEY_WORD_W-1:0] words_q [KEY_WORDS];
    logic [KEY_WORDS-2:0]  seen_q;
    logic [63:0]           key_flat;
    logic                  hw_clr;

    assign hw_clr = !por_n || !rst_n;

    always_comb begin
        for (int i = 0; i < KEY_WORDS; i++)
            key_flat[i*KEY_WORD_W +: KEY_WORD_W] = words_q[i];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (close_req) state_d = pw_mode ? LK_SHUT : LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            LK_SHUT:   if (!close_req && word_en && word_idx == LAST && &seen_q)
                           state_d = LK_CHECK;
            LK_CHECK:  if (close_req) state_d = LK_SHUT;
                       else state_d = (key_flat == KEY) ? LK_OPEN : LK_SHUT;
            default:   state_d = LK_SHUT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (hw_clr)
            state_q <= pw_mode ? LK_SHUT : LK_OPEN;
        else
            state_q <= state_d;
    end

    // key word collector
    always_ff @(posedge clk) begin
        if (hw_clr) begin
            seen_q <= '0;
            for (int i = 0; i < KEY_WORDS; i++) words_q[i] <= '0;
        end else if (state_q == LK_SHUT && word_en && !close_req) begin
            if (word_idx == LAST) begin
                if (&seen_q) words_q[LAST] <= word_val;
                else         seen_q <= '0;
            end else begin
                words_q[word_idx] <= word_val;
                seen_q[word_idx]  <= 1'b1;
            end
        end else if (state_q != LK_SHUT) begin
            seen_q <= '0;
        end
    end

    // outputs
    always_comb begin
        gate = (state_q == LK_OPEN);
    end

    // R6
    sealed_hold_chk: assert property (@(posedge clk) disable iff (hw_clr)
        (state_q == LK_SEALED) |=> (state_q == LK_SEALED));

    // R8
    shut_no_jump_chk: assert property (@(posedge clk) disable iff (hw_clr)
        (state_q == LK_SHUT) |=> (state_q != LK_OPEN));
endmodule

// File: rtl/sector_guard.sv
module sector_guard
    import sg_pkg::*;
#(
    parameter int          N   = 256,
    parameter int          SW  = $clog2(N),
    parameter logic [63:0] KEY = 64'hC3A5_0F1E_7B29_D486
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          pw_mode,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_addr,
    input  logic [15:0]   cmd_data,
    input  logic [SW-1:0] query_sector,
    output logic [2:0]    status_out,
    output logic          prot_out,
    output logic          gate_out
);
    sg_op_e       op;
    logic         run, hw_clr, gate;
    logic         dyn_bit, per_bit;
    logic [N-1:0] dyn_vec, per_vec;

    assign op     = sg_op_e'(cmd_op);
    assign hw_clr = !por_n || !rst_n;
    assign run    = cmd_valid && !hw_clr;

    sg_bit_array #(.N(N), .AW(SW)) u_dyn (
        .clk      (clk),
        .clr      (hw_clr),
        .set_en   (run && (op == OP_DYN_LOCK || op == OP_DYN_FREE)),
        .set_idx  (cmd_addr),
        .set_val  (op == OP_DYN_FREE),
        .fill_en  (1'b0),
        .fill_val (1'b1),
        .rd_idx   (query_sector),
        .rd_bit   (dyn_bit),
        .bits     (dyn_vec)
    );

    sg_bit_array #(.N(N), .AW(SW)) u_per (
        .clk      (clk),
        .clr      (!por_n),
        .set_en   (run && gate && op == OP_PER_PROG),
        .set_idx  (cmd_addr),
        .set_val  (1'b0),
        .fill_en  (run && gate && op == OP_PER_WIPE),
        .fill_val (1'b1),
        .rd_idx   (query_sector),
        .rd_bit   (per_bit),
        .bits     (per_vec)
    );

    sg_key_gate #(.KEY(KEY)) u_gate (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .pw_mode   (pw_mode),
        .close_req (run && op == OP_GATE_CLOSE),
        .word_en   (run && op == OP_KEY_WORD),
        .word_idx  (cmd_addr[KEY_IDX_W-1:0]),
        .word_val  (cmd_data),
        .gate      (gate)
    );

    always_comb begin
        status_out = {per_bit, dyn_bit, per_bit & dyn_bit};
        prot_out   = !(per_bit & dyn_bit);
        gate_out   = gate;
    end

    // R5
    gate_reject_chk: assert property (@(posedge clk) disable iff (hw_clr)
        (cmd_valid && (op == OP_PER_PROG || op == OP_PER_WIPE) && !gate)
        |=> $stable(per_vec));

    // R2
    keep_on_hwreset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> $stable(per_vec));

    // R2
    dyn_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> (&dyn_vec));
endmodule

// File: tb/tb_sector_guard.sv
module tb_sector_guard;
    localparam int          N   = 256;
    localparam int          SW  = 8;
    localparam logic [63:0] KEY = 64'hC3A5_0F1E_7B29_D486;

    logic          clk = 0;
    logic          por_n, rst_n, pw_mode, cmd_valid;
    logic [2:0]    cmd_op;
    logic [SW-1:0] cmd_addr, query_sector;
    logic [15:0]   cmd_data;
    logic [2:0]    status_out;
    logic          prot_out, gate_out;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [N-1:0] m_dyn, m_per;
    logic         m_gate;

    always #10 clk = ~clk;

    sector_guard #(.N(N), .SW(SW), .KEY(KEY)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .pw_mode(pw_mode),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .query_sector(query_sector),
        .status_out(status_out), .prot_out(prot_out), .gate_out(gate_out)
    );

    function automatic logic [2:0] exp_status(int s);
        return {m_per[s], m_dyn[s], m_per[s] & m_dyn[s]};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_sector(string req, int s);
        query_sector = SW'(s);
        #1;
        check(req, {29'd0, status_out}, {29'd0, exp_status(s)});
        check(req, {31'd0, prot_out}, {31'd0, ~(m_per[s] & m_dyn[s])});
    endtask

    // drive at negedge, hold one cycle, return at next negedge
    task automatic do_cmd(logic [2:0] op, int addr, logic [15:0] data);
        cmd_valid = 1; cmd_op = op; cmd_addr = SW'(addr); cmd_data = data;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
    endtask

    // model of ops 0..5 and 7 (op 6 handled by directed code)
    task automatic model_cmd(logic [2:0] op, int addr);
        case (op)
            3'd1: m_dyn[addr] = 1'b0;
            3'd2: m_dyn[addr] = 1'b1;
            3'd3: if (m_gate) m_per[addr] = 1'b0;
            3'd4: if (m_gate) m_per = '1;
            3'd5: m_gate = 1'b0;
            default: ;
        endcase
    endtask

    task automatic power_on(logic mode);
        por_n = 0; rst_n = 1; pw_mode = mode;
        @(negedge clk); @(negedge clk);
        por_n = 1;
        m_dyn = '1; m_per = '1; m_gate = !mode;
    endtask

    task automatic send_key(logic [63:0] k, int o0, int o1, int o2, int o3);
        do_cmd(3'd6, o0, k[o0*16 +: 16]);
        do_cmd(3'd6, o1, k[o1*16 +: 16]);
        do_cmd(3'd6, o2, k[o2*16 +: 16]);
        do_cmd(3'd6, o3, k[o3*16 +: 16]);
    endtask

    task automatic random_phase(int n, bit allow_close, bit allow_key);
        for (int i = 0; i < n; i++) begin
            logic [2:0] op;
            int a;
            op = 3'($urandom_range(0, 7));
            a  = $urandom_range(0, N - 1);
            if (op == 3'd5 && (!allow_close || $urandom_range(0, 9) != 0)) op = 3'd3;
            if (op == 3'd6 && !allow_key) op = 3'd7;
            do_cmd(op, a, 16'($urandom));
            model_cmd(op, a);
            check_sector("R3/R4/R5/R9 random", a);
            check_sector("R3 random query", $urandom_range(0, N - 1));
            check("R6/R7 gate random", {31'd0, gate_out}, {31'd0, m_gate});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0; query_sector = 0;
        @(negedge clk);

        // latch mode
        power_on(1'b0);
        check_sector("R1 reset sector 0", 0);
        check_sector("R1 reset sector top", N - 1);
        check("R6 gate open after reset", {31'd0, gate_out}, 32'd1);

        do_cmd(3'd1, 5, 0); model_cmd(3'd1, 5);
        check_sector("R4 dyn lock", 5);
        do_cmd(3'd3, 9, 0); model_cmd(3'd3, 9);
        check_sector("R5 per program open", 9);
        do_cmd(3'd0, 9, 0); check_sector("R9 nop", 9);
        do_cmd(3'd7, 5, 0); check_sector("R9 reserved", 5);
        random_phase(300, 0, 1);
        do_cmd(3'd4, 0, 0); model_cmd(3'd4, 0);
        check("R5 wipe all", {31'd0, (m_per == '1)}, 32'd1);
        check_sector("R5 wipe sector", 9);
        do_cmd(3'd3, 12, 0); model_cmd(3'd3, 12);
        do_cmd(3'd5, 0, 0); model_cmd(3'd5, 0);
        check("R6 gate closed", {31'd0, gate_out}, 32'd0);
        do_cmd(3'd3, 20, 0); model_cmd(3'd3, 20);
        check_sector("R5 program rejected", 20);
        do_cmd(3'd4, 0, 0); model_cmd(3'd4, 0);
        check_sector("R5 wipe rejected", 12);
        send_key(KEY, 0, 1, 2, 3);
        @(negedge clk);
        check("R6 key ignored in latch mode", {31'd0, gate_out}, 32'd0);
        random_phase(200, 0, 1);

        // hardware reset keeps persistent bits
        do_cmd(3'd1, 33, 0); model_cmd(3'd1, 33);
        rst_n = 0; cmd_valid = 1; cmd_op = 3'd2; cmd_addr = 8'd40;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0; rst_n = 1;
        m_dyn = '1; m_gate = 1'b1;
        check_sector("R2 dyn cleared", 33);
        check_sector("R2 per kept", 12);
        check("R2 per kept bit", {31'd0, status_out[2]}, 32'd0);
        check("R6 gate reopens at reset", {31'd0, gate_out}, 32'd1);

        // key mode
        power_on(1'b1);
        check_sector("R1 por clears per", 12);
        check("R7 gate shut after reset", {31'd0, gate_out}, 32'd0);
        do_cmd(3'd3, 7, 0); model_cmd(3'd3, 7);
        check_sector("R5 rejected in key mode", 7);
        send_key(KEY ^ 64'h1, 0, 1, 2, 3);
        @(negedge clk);
        check("R8 mismatch stays shut", {31'd0, gate_out}, 32'd0);
        do_cmd(3'd6, 0, KEY[15:0]); do_cmd(3'd6, 1, KEY[31:16]);
        do_cmd(3'd6, 3, KEY[63:48]);
        @(negedge clk);
        check("R8 early last word", {31'd0, gate_out}, 32'd0);
        do_cmd(3'd6, 2, KEY[47:32]); do_cmd(3'd6, 3, KEY[63:48]);
        @(negedge clk);
        check("R8 stale words discarded", {31'd0, gate_out}, 32'd0);
        send_key(KEY, 2, 0, 1, 3);
        check("R8 compare cycle still shut", {31'd0, gate_out}, 32'd0);
        @(negedge clk);
        check("R8 match opens", {31'd0, gate_out}, 32'd1);
        m_gate = 1'b1;
        do_cmd(3'd3, 7, 0); model_cmd(3'd3, 7);
        check_sector("R5 program after unlock", 7);
        random_phase(200, 1, 0);
        do_cmd(3'd5, 0, 0); model_cmd(3'd5, 0);
        check("R7 close in key mode", {31'd0, gate_out}, 32'd0);
        send_key(KEY, 0, 1, 2, 3);
        @(negedge clk);
        check("R8 reopen after close", {31'd0, gate_out}, 32'd1);
        m_gate = 1'b1;
        random_phase(200, 1, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule